// File: doc/BRIEF.md
# Dual Reload-Compare Down Timer

The block holds two 8-bit down counters that advance on a per-channel count tick while they are running. Each channel has a reload byte, a compare byte, a preset strobe and a run bit. When a counter steps past zero it refills from its reload byte. When its value equals the compare byte, the channel raises a one-cycle interrupt pulse and ends the high phase of its waveform output. The result is a PWM signal: high from each reload until the compare point.

Setting the wide-mode bit joins the two channels into one 16-bit timer. Channel 0 is the low byte and channel 1 the high byte. A borrow out of the low byte decrements the high byte. Channel 0's preset and run bits then control both halves. Channel 1's controls, interrupt and waveform are idle in this mode. Software reaches the block through a small byte-wide port with separate write and read addresses. Reads are combinational.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset the two reload bytes read 0xFF, the two compare bytes read 0x00 and both counters read 0xFF. Both run bits and the wide bit read 0, and all irq and tout outputs are low. Address map: 0 = control 0, 1 = control 1, 2/3 = reload 0/1, 4/5 = compare 0/1, 6/7 = counter 0/1.
- R2: A counter decrements by one on each clock edge where its tick input is high and its run bit (control bit 0) is 1. It holds its value when stopped. Setting the run bit again resumes counting from the held value.
- R3: A counting tick taken while the counter is 0x00 loads the reload byte instead of decrementing. The channel's tout goes high at that same edge.
- R4: Writing a control byte with bit 1 set loads the reload byte into the counter at that edge. A running counter then keeps counting from the loaded value, and a stopped counter holds it. Writing bit 1 as 0 loads nothing. Bit 1 always reads 0.
- R5: The irq output is high for exactly the first cycle in which the counter equals the compare byte. tout goes low at the edge after the counter equals the compare byte, unless a reload happens at that edge.
- R6: Writes to addresses 6 and 7 change nothing. Reload and compare bytes read back the value last written.
- R7: Control 0 bit 2 selects wide mode. In wide mode the pair {counter 1, counter 0} steps down as one 16-bit value on channel 0 ticks. When the pair reaches 0x0000, the next tick loads {reload 1, reload 0}. Each counter byte reads its live value; reading one byte does not capture the other.
- R8: In wide mode a preset through control 0 loads both counter bytes. A preset through control 1 is ignored.
- R9: In wide mode the channel 0 run bit governs both halves and the channel 1 run bit reads 0 and ignores writes. The channel 0 match compares all 16 bits, and irq1 and tout1 stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data for rd_addr, combinational |
| tick0 | input | 1 | Count enable for channel 0 |
| tick1 | input | 1 | Count enable for channel 1 |
| irq0 | output | 1 | Channel 0 compare-match pulse |
| irq1 | output | 1 | Channel 1 compare-match pulse |
| tout0 | output | 1 | Channel 0 PWM waveform |
| tout1 | output | 1 | Channel 1 PWM waveform |

## Verification
The hardest situation to reach is the 16-bit wrap. The high byte must fall to zero through borrows from the low byte, and then a further channel 0 tick must refill both bytes at once. It is only visible after hundreds of ticks. The stimulus first presets a small 16-bit reload value just above 0x0100 with a compare at 0x0100. It then runs the joined counter with channel 1 ticks held high throughout, which shows that they are ignored. It keeps going until the pair wraps. A reference model in the bench tracks every cycle, so each read of either counter byte on the way is checked, including reads of a torn value.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

    localparam int DW  = 8;
    localparam int NCH = 2;
    localparam int AW  = 3;

    typedef logic [DW-1:0] byte_t;

    // register addresses
    localparam logic [AW-1:0] A_CTL0 = 3'd0;
    localparam logic [AW-1:0] A_CTL1 = 3'd1;
    localparam logic [AW-1:0] A_REL0 = 3'd2;
    localparam logic [AW-1:0] A_REL1 = 3'd3;
    localparam logic [AW-1:0] A_CMP0 = 3'd4;
    localparam logic [AW-1:0] A_CMP1 = 3'd5;
    localparam logic [AW-1:0] A_CNT0 = 3'd6;
    localparam logic [AW-1:0] A_CNT1 = 3'd7;

    // control byte fields
    localparam int B_RUN  = 0;
    localparam int B_PSET = 1;
    localparam int B_WIDE = 2;

    localparam byte_t RELOAD_RST = '1;
    localparam byte_t CMP_RST    = '0;
    localparam byte_t CNT_RST    = '1;

    // per-lane step command
    typedef struct packed {
        logic load;   // preset from reload byte
        logic dec;    // take a counting step
        logic wrap;   // counting step refills instead of decrementing
    } lane_ctl_t;

    function automatic logic is_zero(input byte_t v);
        return v == '0;
    endfunction

endpackage

// File: rtl/dtmr_regs.sv
module dtmr_regs
    import dtmr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [DW-1:0]        wr_data,
    input  logic [AW-1:0]        rd_addr,
    output logic [DW-1:0]        rd_data,
    input  byte_t [NCH-1:0]      cnt_i,
    output byte_t [NCH-1:0]      rel_o,
    output byte_t [NCH-1:0]      cmp_o,
    output logic  [NCH-1:0]      run_o,
    output logic  [NCH-1:0]      preset_o,
    output logic                 wide_o
);

    logic [NCH-1:0] ctl_wr;
    logic           wide_q;
    logic           wide_next;

    assign wide_next = (wr_en && wr_addr == A_CTL0) ? wr_data[B_WIDE] : wide_q;

    always_ff @(posedge clk) begin
        if (rst) wide_q <= 1'b0;
        else     wide_q <= wide_next;
    end

    genvar k;
    generate
        for (k = 0; k < NCH; k++) begin : g_ch
            localparam logic [AW-1:0] CTL_A = A_CTL0 + AW'(k);
            localparam logic [AW-1:0] REL_A = A_REL0 + AW'(k);
            localparam logic [AW-1:0] CMP_A = A_CMP0 + AW'(k);

            assign ctl_wr[k] = wr_en && (wr_addr == CTL_A);

            always_ff @(posedge clk) begin
                if (rst) begin
                    rel_o[k] <= RELOAD_RST;
                    cmp_o[k] <= CMP_RST;
                end else begin
                    if (wr_en && wr_addr == REL_A) rel_o[k] <= wr_data;
                    if (wr_en && wr_addr == CMP_A) cmp_o[k] <= wr_data;
                end
            end

            if (k == 0) begin : g_lead
                assign preset_o[k] = ctl_wr[k] && wr_data[B_PSET];
                always_ff @(posedge clk) begin
                    if (rst)            run_o[k] <= 1'b0;
                    else if (ctl_wr[k]) run_o[k] <= wr_data[B_RUN];
                end
            end else begin : g_follow
                assign preset_o[k] = ctl_wr[k] && wr_data[B_PSET] && !wide_q;
                always_ff @(posedge clk) begin
                    if (rst)            run_o[k] <= 1'b0;
                    else if (wide_next) run_o[k] <= 1'b0;
                    else if (ctl_wr[k]) run_o[k] <= wr_data[B_RUN];
                end
            end
        end
    endgenerate

    assign wide_o = wide_q;

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTL0: begin
                rd_data[B_RUN]  = run_o[0];
                rd_data[B_WIDE] = wide_q;
            end
            A_CTL1: rd_data[B_RUN] = run_o[1];
            A_REL0: rd_data = rel_o[0];
            A_REL1: rd_data = rel_o[1];
            A_CMP0: rd_data = cmp_o[0];
            A_CMP1: rd_data = cmp_o[1];
            A_CNT0: rd_data = cnt_i[0];
            default: rd_data = cnt_i[1];
        endcase
    end

    AST_PSET_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == A_CTL0 || rd_addr == A_CTL1) |-> !rd_data[B_PSET]); // R4
    AST_WIDE_RUN1_LOW: assert property (@(posedge clk) disable iff (rst)
        wide_q |-> !run_o[1]); // R9

endmodule

// File: rtl/dtmr_lane.sv
module dtmr_lane
    import dtmr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  lane_ctl_t ctl,
    input  byte_t     rel,
    output byte_t     cnt_o,
    output logic      zero_o,
    output logic      reload_evt_o
);

    byte_t cnt_q;

    always_ff @(posedge clk) begin
        if (rst)           cnt_q <= CNT_RST;
        else if (ctl.load) cnt_q <= rel;
        else if (ctl.dec)  cnt_q <= ctl.wrap ? rel : cnt_q - 1'b1;
    end

    assign cnt_o        = cnt_q;
    assign zero_o       = is_zero(cnt_q);
    assign reload_evt_o = ctl.load | (ctl.dec & ctl.wrap);

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ctl.load && !ctl.dec) |=> $stable(cnt_q)); // R2

endmodule

// File: rtl/dtmr_wave.sv
module dtmr_wave (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic match,
    input  logic reload_evt,
    output logic irq_o,
    output logic tout_o
);

    logic match_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            match_d <= 1'b0;
            tout_o  <= 1'b0;
        end else begin
            match_d <= match;
            if (!en)             tout_o <= 1'b0;
            else if (reload_evt) tout_o <= 1'b1;
            else if (match)      tout_o <= 1'b0;
        end
    end

    assign irq_o = en && match && !match_d;

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq_o |=> !irq_o); // R5
    AST_TOUT_ON_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (en && reload_evt) |=> tout_o); // R3

endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
    import dtmr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [2:0]    rd_addr,
    output logic [7:0]    rd_data,
    input  logic          tick0,
    input  logic          tick1,
    output logic          irq0,
    output logic          irq1,
    output logic          tout0,
    output logic          tout1
);

    byte_t [NCH-1:0]     cnt;
    byte_t [NCH-1:0]     rel;
    byte_t [NCH-1:0]     cmp;
    logic  [NCH-1:0]     run;
    logic  [NCH-1:0]     preset;
    logic  [NCH-1:0]     zero;
    logic  [NCH-1:0]     reload_evt;
    logic  [NCH-1:0]     match;
    logic  [NCH-1:0]     wave_en;
    logic  [NCH-1:0]     irq_v;
    logic  [NCH-1:0]     tout_v;
    logic  [NCH-1:0]     tick_v;
    lane_ctl_t [NCH-1:0] ctl;
    logic                wide;

    assign tick_v = {tick1, tick0};

    dtmr_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .cnt_i    (cnt),
        .rel_o    (rel),
        .cmp_o    (cmp),
        .run_o    (run),
        .preset_o (preset),
        .wide_o   (wide)
    );

    // step commands: independent bytes, or one 16-bit value with borrow
    always_comb begin
        for (int k = 0; k < NCH; k++) begin
            ctl[k].load = preset[k];
            ctl[k].dec  = run[k] & tick_v[k];
            ctl[k].wrap = zero[k];
        end
        if (wide) begin
            ctl[1].load = preset[0];
            ctl[1].dec  = run[0] & tick_v[0] & zero[0];
            ctl[0].wrap = zero[0] & zero[1];
            ctl[1].wrap = zero[0] & zero[1];
        end
    end

    assign match[0] = wide ? ({cnt[1], cnt[0]} == {cmp[1], cmp[0]}) : (cnt[0] == cmp[0]);
    assign match[1] = !wide && (cnt[1] == cmp[1]);

    genvar k;
    generate
        for (k = 0; k < NCH; k++) begin : g_ch
            if (k == 0) begin : g_en_lead
                assign wave_en[k] = 1'b1;
            end else begin : g_en_follow
                assign wave_en[k] = !wide;
            end

            dtmr_lane u_lane (
                .clk          (clk),
                .rst          (rst),
                .ctl          (ctl[k]),
                .rel          (rel[k]),
                .cnt_o        (cnt[k]),
                .zero_o       (zero[k]),
                .reload_evt_o (reload_evt[k])
            );

            dtmr_wave u_wave (
                .clk        (clk),
                .rst        (rst),
                .en         (wave_en[k]),
                .match      (match[k]),
                .reload_evt (reload_evt[k]),
                .irq_o      (irq_v[k]),
                .tout_o     (tout_v[k])
            );
        end
    endgenerate

    assign irq0  = irq_v[0];
    assign irq1  = irq_v[1];
    assign tout0 = tout_v[0];
    assign tout1 = tout_v[1];

    AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (!run[0] && !preset[0]) |=> $stable(cnt[0])); // R2
    AST_WIDE_CH1_QUIET: assert property (@(posedge clk) disable iff (rst)
        wide |-> !irq1); // R9
    AST_WIDE_TOUT1_LOW: assert property (@(posedge clk) disable iff (rst)
        (wide && $past(wide)) |-> !tout1); // R9
    AST_WIDE_PRESET_HIGH: assert property (@(posedge clk) disable iff (rst)
        (wide && preset[0]) |=> (cnt[1] == $past(rel[1]))); // R8

endmodule

// File: tb/dual_reload_timer_tb.sv
`timescale 1ns/1ps
module dual_reload_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       tick0 = 1'b0;
    logic       tick1 = 1'b0;
    logic       irq0, irq1, tout0, tout1;

    always #2.5 clk = ~clk;

    dual_reload_timer dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .tick0(tick0), .tick1(tick1),
        .irq0(irq0), .irq1(irq1), .tout0(tout0), .tout1(tout1)
    );

    typedef struct {
        logic [7:0] rd;
        logic       i0, i1, t0, t1;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 0;

    // reference model state
    logic [7:0] m_c0 = 8'hFF, m_c1 = 8'hFF, m_r0 = 8'hFF, m_r1 = 8'hFF, m_p0 = 8'h00, m_p1 = 8'h00;
    logic       m_run0 = 0, m_run1 = 0, m_wide = 0, m_t0 = 0, m_t1 = 0, m_d0 = 0, m_d1 = 0;

    function automatic logic [7:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return {5'b0, m_wide, 1'b0, m_run0};
            3'd1: return {7'b0, m_run1};
            3'd2: return m_r0;
            3'd3: return m_r1;
            3'd4: return m_p0;
            3'd5: return m_p1;
            3'd6: return m_c0;
            default: return m_c1;
        endcase
    endfunction

    // driver: one clock cycle of stimulus, then the expected outputs go to the queue
    task automatic step(input logic we, input logic [2:0] wa, input logic [7:0] wd,
                        input logic [2:0] ra, input logic t0, input logic t1, input string tag);
        logic w0, w1, ld0, ld1, mt0, mt1, nw;
        logic [7:0] n0, n1;
        exp_t e;
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra; tick0 = t0; tick1 = t1;
        @(posedge clk);
        w0 = we && wa == 3'd0;
        w1 = we && wa == 3'd1;
        mt0 = m_wide ? ({m_c1, m_c0} == {m_p1, m_p0}) : (m_c0 == m_p0);
        mt1 = !m_wide && (m_c1 == m_p1);
        ld0 = 0; ld1 = 0; n0 = m_c0; n1 = m_c1;
        if (m_wide) begin
            if (w0 && wd[1]) begin n0 = m_r0; n1 = m_r1; ld0 = 1; end
            else if (m_run0 && t0) begin
                if ({m_c1, m_c0} == 16'h0) begin n0 = m_r0; n1 = m_r1; ld0 = 1; end
                else {n1, n0} = {m_c1, m_c0} - 16'd1;
            end
        end else begin
            if (w0 && wd[1]) begin n0 = m_r0; ld0 = 1; end
            else if (m_run0 && t0) begin
                if (m_c0 == 0) begin n0 = m_r0; ld0 = 1; end else n0 = m_c0 - 8'd1;
            end
            if (w1 && wd[1]) begin n1 = m_r1; ld1 = 1; end
            else if (m_run1 && t1) begin
                if (m_c1 == 0) begin n1 = m_r1; ld1 = 1; end else n1 = m_c1 - 8'd1;
            end
        end
        m_t0 = ld0 ? 1'b1 : (mt0 ? 1'b0 : m_t0);
        m_t1 = m_wide ? 1'b0 : (ld1 ? 1'b1 : (mt1 ? 1'b0 : m_t1));
        m_d0 = mt0; m_d1 = mt1;
        m_c0 = n0; m_c1 = n1;
        if (we && wa == 3'd2) m_r0 = wd;
        if (we && wa == 3'd3) m_r1 = wd;
        if (we && wa == 3'd4) m_p0 = wd;
        if (we && wa == 3'd5) m_p1 = wd;
        nw = w0 ? wd[2] : m_wide;
        if (w0) m_run0 = wd[0];
        if (nw) m_run1 = 0; else if (w1) m_run1 = wd[0];
        m_wide = nw;
        mt0 = m_wide ? ({m_c1, m_c0} == {m_p1, m_p0}) : (m_c0 == m_p0);
        mt1 = !m_wide && (m_c1 == m_p1);
        e.rd = m_read(ra);
        e.i0 = mt0 && !m_d0;
        e.i1 = mt1 && !m_d1;
        e.t0 = m_t0;
        e.t1 = m_t1;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n, input logic t0, input logic t1, input string tag);
        for (int i = 0; i < n; i++)
            step(0, 3'd0, 8'h00, (i % 2 == 0) ? 3'd6 : 3'd7, t0, t1, tag);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic [2:0] ra, input string tag);
        step(1, a, d, ra, 0, 0, tag);
    endtask

    // monitor: compares each produced cycle against the queued expectation
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_checks++;
                if (rd_data !== e.rd || irq0 !== e.i0 || irq1 !== e.i1 ||
                    tout0 !== e.t0 || tout1 !== e.t1) begin
                    n_fails++;
                    $display("FAIL %s: rd=%h irq=%b%b tout=%b%b expected rd=%h irq=%b%b tout=%b%b",
                             e.tag, rd_data, irq0, irq1, tout0, tout1,
                             e.rd, e.i0, e.i1, e.t0, e.t1);
                end
            end
        end
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state on every address
        for (int a = 0; a < 8; a++) step(0, 3'd0, 8'h00, 3'(a), 0, 0, "R1 reset");

        // R4: preset while stopped holds loaded value
        wr(3'd2, 8'h05, 3'd2, "R6 reload0 readback");
        wr(3'd4, 8'h02, 3'd4, "R6 cmp0 readback");
        wr(3'd0, 8'h02, 3'd6, "R4 preset stopped");
        idle(3, 1, 0, "R4 stopped holds");
        wr(3'd0, 8'h00, 3'd0, "R4 pset bit 0 no load");
        // R2 R3 R5: run with continuous ticks through compare and underflow
        wr(3'd0, 8'h01, 3'd0, "R2 run0 readback");
        idle(16, 1, 0, "R3 R5 count wrap");
        // R2: sparse ticks
        for (int i = 0; i < 12; i++) step(0, 3'd0, 8'h00, 3'd6, (i % 3 == 0), 0, "R2 sparse ticks");
        // R2: stop freezes, resume continues
        wr(3'd0, 8'h00, 3'd6, "R2 stop");
        idle(4, 1, 0, "R2 frozen");
        wr(3'd0, 8'h01, 3'd6, "R2 resume");
        idle(4, 1, 0, "R2 resumed");
        // R4: preset while running continues from reload
        step(1, 3'd0, 8'h03, 3'd6, 1, 0, "R4 preset running");
        idle(4, 1, 0, "R4 counting after preset");

        // R6: counter writes ignored
        wr(3'd6, 8'h33, 3'd6, "R6 cnt0 write ignored");
        wr(3'd7, 8'h44, 3'd7, "R6 cnt1 write ignored");

        // channel 1 on its own
        wr(3'd3, 8'h03, 3'd3, "R6 reload1 readback");
        wr(3'd5, 8'h01, 3'd5, "R6 cmp1 readback");
        wr(3'd1, 8'h03, 3'd1, "R4 ch1 preset and run");
        idle(12, 0, 1, "R3 R5 ch1 count");
        idle(6, 1, 1, "R2 both channels");

        // R9 R8 R7: wide mode
        wr(3'd0, 8'h04, 3'd1, "R9 wide clears run1");
        wr(3'd1, 8'h03, 3'd1, "R9 run1 write ignored");
        wr(3'd2, 8'h02, 3'd0, "R9 wide bit readback");
        wr(3'd3, 8'h01, 3'd7, "R8 ch1 preset ignored");
        wr(3'd4, 8'h00, 3'd6, "R7 cmp low");
        wr(3'd5, 8'h01, 3'd7, "R7 cmp high");
        wr(3'd0, 8'h06, 3'd7, "R8 wide preset both");
        step(0, 3'd0, 8'h00, 3'd6, 1, 1, "R9 stopped in wide");
        wr(3'd0, 8'h05, 3'd6, "R9 run0 wide");
        idle(270, 1, 1, "R7 wide count and wrap");
        wr(3'd0, 8'h04, 3'd6, "R9 stop wide");
        idle(4, 1, 1, "R9 wide frozen");

        // back to independent bytes
        wr(3'd0, 8'h01, 3'd0, "R7 leave wide");
        wr(3'd1, 8'h01, 3'd1, "R9 run1 writable again");
        idle(12, 1, 1, "R2 independent again");

        @(posedge clk);
        #2;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule